// File: doc/BRIEF.md
# Floating-Point Register Block Transfer Sequencer

This block turns one floating-point register load or store command into the stream of memory accesses it implies. A command carries a base address, an 8-bit immediate, and control bits for direction of offset (up), pre-decrement, base writeback, load versus store and single versus double precision, plus the index of the first register. When the pre-decrement bit is set and writeback is clear, the command is a single transfer at an offset address. Every other combination is a multiple transfer that walks a run of consecutive registers and consecutive memory words.

The block accepts a command when it is idle. It then issues one transfer per cycle on a valid/ready handshake, each carrying the memory address, the register index and the direction. When the sequence finishes it pulses a completion strobe with the base value that should be written back. Memory and the register file sit outside the block.

Top module: `fpreg_block_xfer`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `xfer_valid` and `done_valid` are 0.
- R2: A command with `cmd_pre`=1 and `cmd_wback`=0 is a single transfer. It makes exactly one transfer to register `cmd_first`, at address `cmd_base + cmd_imm*4` when `cmd_up`=1 and `cmd_base - cmd_imm*4` when `cmd_up`=0. Completion reports `done_wb`=0 and `done_base`=`cmd_base`.
- R3: A multiple transfer makes `cmd_imm` transfers in single precision (`cmd_dbl`=0) and `cmd_imm>>1` transfers in double precision (`cmd_dbl`=1).
- R4: The first address of a multiple transfer is `cmd_base - cmd_imm*4` when `cmd_pre`=1 and `cmd_base` otherwise. `cmd_up` has no effect on a multiple transfer.
- R5: Within a multiple transfer, each successive address is 4 higher in single precision and 8 higher in double precision. Each successive register index is one higher, modulo 2^REG_W.
- R6: A multiple transfer with writeback and `cmd_pre`=1 reports `done_wb`=1 and `done_base` equal to its first address.
- R7: A multiple transfer with writeback and `cmd_pre`=0 reports `done_base` = `cmd_base + count*step`. In double precision with an odd `cmd_imm`, 4 is added to that value.
- R8: A multiple transfer with `cmd_wback`=0 reports `done_wb`=0 and `done_base`=`cmd_base`.
- R9: A multiple transfer whose count is zero makes no transfer. It raises `done_valid` in the cycle right after the command is accepted.
- R10: A transfer is held unchanged while `xfer_ready` is 0. Each cycle with `xfer_valid` and `xfer_ready` both high consumes exactly one transfer.
- R11: `done_valid` is high for exactly one cycle, in the cycle after the last transfer is consumed. `cmd_ready` is 1 only while idle, so a command presented while busy is not taken.
- R12: `xfer_load` equals the `cmd_load` of the command being executed (1 = load, 0 = store).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Idle, command taken this cycle if valid |
| cmd_base | input | AW | Base address |
| cmd_imm | input | IMM_W | Immediate (word offset or register count) |
| cmd_up | input | 1 | Add offset (1) or subtract (0), single transfer only |
| cmd_pre | input | 1 | Pre-decrement / offset-addressing select |
| cmd_wback | input | 1 | Write back base |
| cmd_load | input | 1 | 1 = load, 0 = store |
| cmd_dbl | input | 1 | 1 = double precision |
| cmd_first | input | REG_W | First register index |
| xfer_valid | output | 1 | Transfer present |
| xfer_ready | input | 1 | Transfer consumed this cycle if valid |
| xfer_addr | output | AW | Transfer memory address |
| xfer_reg | output | REG_W | Transfer register index |
| xfer_load | output | 1 | Transfer direction |
| done_valid | output | 1 | One-cycle completion pulse |
| done_wb | output | 1 | Base writeback requested |
| done_base | output | AW | Value for the base register |

## Verification
The first transfer of a command appears one clock edge after the edge that accepts it. After that, the next transfer appears one edge after each edge where the current one is consumed. The completion pulse comes one edge after the last transfer is consumed, or one edge after acceptance when the count is zero, and `cmd_ready` returns one edge later. The bench keeps a queue of the expected transfers and the expected completion values. At every falling edge it compares the outputs with the head of that queue, and it pops the queue only at a rising edge where it drove `xfer_ready` high. Because the comparison happens at every falling edge, a result that arrives early or late is caught in the cycle it goes wrong, and the ready patterns cover both stall and full-rate streaming.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } seq_state_t;

  localparam int unsigned SP_STEP = 4;
  localparam int unsigned DP_STEP = 8;
endpackage

// File: rtl/fpx_decode.sv
module fpx_decode #(
  parameter int AW    = 32,
  parameter int IMM_W = 8
) (
  input  logic [AW-1:0]    base,
  input  logic [IMM_W-1:0] imm,
  input  logic             up,
  input  logic             pre,
  input  logic             wback,
  input  logic             dbl,
  output logic [IMM_W-1:0] count,
  output logic [AW-1:0]    start,
  output logic             wb_en,
  output logic [AW-1:0]    final_base
);
  logic [AW-1:0]    word_off;
  logic [AW-1:0]    span;
  logic [AW-1:0]    odd_pad;
  logic [IMM_W-1:0] multi_cnt;
  logic             single;

  always_comb begin
    single    = pre && !wback;
    word_off  = AW'(imm) << 2;
    multi_cnt = dbl ? (imm >> 1) : imm;
    span      = dbl ? (AW'(multi_cnt) << 3) : (AW'(multi_cnt) << 2);
    odd_pad   = (dbl && imm[0]) ? AW'(4) : '0;
    if (single) begin
      count      = IMM_W'(1);
      start      = up ? (base + word_off) : (base - word_off);
      wb_en      = 1'b0;
      final_base = base;
    end else begin
      count      = multi_cnt;
      start      = pre ? (base - word_off) : base;
      wb_en      = wback;
      if (!wback)
        final_base = base;
      else if (pre)
        final_base = base - word_off;
      else
        final_base = base + span + odd_pad;
    end
  end
endmodule

// File: rtl/fpx_seq.sv
module fpx_seq
  import fpx_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IMM_W = 8,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [IMM_W-1:0] count,
  input  logic [AW-1:0]    start,
  input  logic             wb_en,
  input  logic [AW-1:0]    final_base,
  input  logic             dbl,
  input  logic             load,
  input  logic [REG_W-1:0] first,
  output logic             xfer_valid,
  input  logic             xfer_ready,
  output logic [AW-1:0]    xfer_addr,
  output logic [REG_W-1:0] xfer_reg,
  output logic             xfer_load,
  output logic             done_valid,
  output logic             done_wb,
  output logic [AW-1:0]    done_base
);
  seq_state_t       state;
  logic [IMM_W-1:0] left;
  logic             dbl_r;
  logic [AW-1:0]    step;

  assign cmd_ready = (state == ST_IDLE);
  assign step      = dbl_r ? AW'(DP_STEP) : AW'(SP_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      left       <= '0;
      dbl_r      <= 1'b0;
      xfer_valid <= 1'b0;
      xfer_addr  <= '0;
      xfer_reg   <= '0;
      xfer_load  <= 1'b0;
      done_valid <= 1'b0;
      done_wb    <= 1'b0;
      done_base  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          done_valid <= 1'b0;
          if (cmd_valid) begin
            xfer_addr <= start;
            xfer_reg  <= first;
            xfer_load <= load;
            left      <= count;
            dbl_r     <= dbl;
            done_wb   <= wb_en;
            done_base <= final_base;
            if (count == '0) begin
              state      <= ST_DONE;
              done_valid <= 1'b1;
            end else begin
              state      <= ST_XFER;
              xfer_valid <= 1'b1;
            end
          end
        end
        ST_XFER: begin
          if (xfer_ready) begin
            if (left == IMM_W'(1)) begin
              xfer_valid <= 1'b0;
              done_valid <= 1'b1;
              state      <= ST_DONE;
            end else begin
              xfer_addr <= xfer_addr + step;
              xfer_reg  <= xfer_reg + REG_W'(1);
              left      <= left - IMM_W'(1);
            end
          end
        end
        default: begin
          done_valid <= 1'b0;
          state      <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/fpreg_block_xfer.sv
module fpreg_block_xfer #(
  parameter int AW    = 32,
  parameter int IMM_W = 8,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [AW-1:0]    cmd_base,
  input  logic [IMM_W-1:0] cmd_imm,
  input  logic             cmd_up,
  input  logic             cmd_pre,
  input  logic             cmd_wback,
  input  logic             cmd_load,
  input  logic             cmd_dbl,
  input  logic [REG_W-1:0] cmd_first,
  output logic             xfer_valid,
  input  logic             xfer_ready,
  output logic [AW-1:0]    xfer_addr,
  output logic [REG_W-1:0] xfer_reg,
  output logic             xfer_load,
  output logic             done_valid,
  output logic             done_wb,
  output logic [AW-1:0]    done_base
);
  logic [IMM_W-1:0] dec_count;
  logic [AW-1:0]    dec_start;
  logic             dec_wb;
  logic [AW-1:0]    dec_final;

  fpx_decode #(.AW(AW), .IMM_W(IMM_W)) decode_i (
    .base(cmd_base), .imm(cmd_imm), .up(cmd_up), .pre(cmd_pre),
    .wback(cmd_wback), .dbl(cmd_dbl),
    .count(dec_count), .start(dec_start), .wb_en(dec_wb),
    .final_base(dec_final)
  );

  fpx_seq #(.AW(AW), .IMM_W(IMM_W), .REG_W(REG_W)) seq_i (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .count(dec_count), .start(dec_start), .wb_en(dec_wb),
    .final_base(dec_final), .dbl(cmd_dbl), .load(cmd_load),
    .first(cmd_first),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
    .xfer_addr(xfer_addr), .xfer_reg(xfer_reg), .xfer_load(xfer_load),
    .done_valid(done_valid), .done_wb(done_wb), .done_base(done_base)
  );
endmodule

// File: rtl/fpreg_block_xfer_chk.sv
module fpreg_block_xfer_chk #(
  parameter int AW    = 32,
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_ready,
  input logic             xfer_valid,
  input logic             xfer_ready,
  input logic [AW-1:0]    xfer_addr,
  input logic [REG_W-1:0] xfer_reg,
  input logic             xfer_load,
  input logic             done_valid
);
  AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_addr) && $stable(xfer_reg))); // R10

  AST_ADDR_STRIDE: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && xfer_ready) |=> (!xfer_valid ||
      (xfer_addr - $past(xfer_addr)) == AW'(4) || (xfer_addr - $past(xfer_addr)) == AW'(8))); // R5

  AST_REG_STEP: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && xfer_ready) |=> (!xfer_valid || xfer_reg == $past(xfer_reg) + REG_W'(1))); // R5

  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && xfer_ready) |=> (!xfer_valid || $stable(xfer_load))); // R12

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid); // R11

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(done_valid) |-> !xfer_valid); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (!xfer_valid && !done_valid)); // R11
endmodule

bind fpreg_block_xfer fpreg_block_xfer_chk #(.AW(AW), .REG_W(REG_W)) chk_i (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .xfer_valid(xfer_valid),
  .xfer_ready(xfer_ready), .xfer_addr(xfer_addr), .xfer_reg(xfer_reg),
  .xfer_load(xfer_load), .done_valid(done_valid)
);

// File: tb/fpreg_block_xfer_tb_top.sv
module fpreg_block_xfer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int IMM_W = 8;
  localparam int REG_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [AW-1:0]    cmd_base = '0;
  logic [IMM_W-1:0] cmd_imm = '0;
  logic             cmd_up = 1'b0, cmd_pre = 1'b0, cmd_wback = 1'b0;
  logic             cmd_load = 1'b0, cmd_dbl = 1'b0;
  logic [REG_W-1:0] cmd_first = '0;
  logic             xfer_valid;
  logic             xfer_ready = 1'b0;
  logic [AW-1:0]    xfer_addr;
  logic [REG_W-1:0] xfer_reg;
  logic             xfer_load;
  logic             done_valid, done_wb;
  logic [AW-1:0]    done_base;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpreg_block_xfer #(.AW(AW), .IMM_W(IMM_W), .REG_W(REG_W)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural model: expected transfer list and completion, compared each cycle.
  task automatic run_cmd(input string tag, input logic [31:0] base, input int imm,
                         input bit up, input bit pre, input bit wb, input bit ld,
                         input bit dbl, input int first, input int rdy_mode,
                         input bit poke);
    logic [31:0] q_addr[$];
    int          q_reg[$];
    logic [31:0] exp_base, a;
    bit          exp_wb;
    int          cnt, step, cyc;
    bit          rdy;
    step = dbl ? 8 : 4;
    if (pre && !wb) begin
      cnt = 1;
      a = up ? base + imm*4 : base - imm*4;
      exp_wb = 0; exp_base = base;
    end else begin
      cnt = dbl ? (imm >> 1) : imm;
      a = pre ? base - imm*4 : base;
      exp_wb = wb;
      if (!wb) exp_base = base;
      else if (pre) exp_base = a;
      else exp_base = base + cnt*step + ((dbl && imm % 2 == 1) ? 4 : 0);
    end
    for (int i = 0; i < cnt; i++) begin
      q_addr.push_back(a + i*step);
      q_reg.push_back((first + i) % 256);
    end
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R11", "cmd_ready idle", cmd_ready, 1);
    cmd_valid = 1; cmd_base = base; cmd_imm = IMM_W'(imm); cmd_up = up;
    cmd_pre = pre; cmd_wback = wb; cmd_load = ld; cmd_dbl = dbl;
    cmd_first = REG_W'(first);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = poke;
    if (poke) begin cmd_base = 32'hDEAD0000; cmd_imm = 8'd7; cmd_pre = 0; cmd_wback = 1; end
    cyc = 0;
    while (q_addr.size() > 0) begin
      chk(xfer_valid == 1'b1, tag, "xfer_valid", xfer_valid, 1);
      chk(xfer_addr == q_addr[0], tag, "xfer_addr", xfer_addr, q_addr[0]);
      chk(int'(xfer_reg) == q_reg[0], tag, "xfer_reg", xfer_reg, q_reg[0]);
      chk(xfer_load == ld, "R12", "xfer_load", xfer_load, ld);
      chk(done_valid == 1'b0, "R11", "done early", done_valid, 0);
      chk(cmd_ready == 1'b0, "R11", "cmd_ready busy", cmd_ready, 0);
      rdy = (rdy_mode == 0) || (cyc % (rdy_mode + 1) == 0);
      xfer_ready = rdy;
      @(posedge clk);
      if (rdy) begin void'(q_addr.pop_front()); void'(q_reg.pop_front()); end
      @(negedge clk);
      xfer_ready = 0;
      cyc++;
    end
    cmd_valid = 0;
    chk(xfer_valid == 1'b0, tag, "xfer_valid after last", xfer_valid, 0);
    chk(done_valid == 1'b1, tag, "done_valid", done_valid, 1);
    chk(done_wb == exp_wb, tag, "done_wb", done_wb, exp_wb);
    chk(done_base == exp_base, tag, "done_base", done_base, exp_base);
    @(negedge clk);
    chk(done_valid == 1'b0, "R11", "done pulse width", done_valid, 0);
    chk(cmd_ready == 1'b1, "R11", "ready after done", cmd_ready, 1);
    chk(xfer_valid == 1'b0, "R11", "no xfer from busy command", xfer_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk(cmd_ready == 1'b1, "R1", "reset cmd_ready", cmd_ready, 1);
    chk(xfer_valid == 1'b0, "R1", "reset xfer_valid", xfer_valid, 0);
    chk(done_valid == 1'b0, "R1", "reset done_valid", done_valid, 0);
    run_cmd("R2", 32'h1000, 5, 1, 1, 0, 1, 0, 3, 0, 0);
    run_cmd("R2", 32'h1000, 5, 0, 1, 0, 0, 1, 7, 1, 0);
    run_cmd("R8", 32'h4000, 3, 1, 0, 0, 1, 0, 10, 0, 0);
    run_cmd("R3", 32'h4000, 4, 1, 0, 1, 0, 0, 0, 1, 0);
    run_cmd("R5", 32'h8000, 6, 1, 0, 1, 1, 1, 2, 2, 0);
    run_cmd("R7", 32'h8000, 5, 1, 0, 1, 1, 1, 4, 0, 0);
    run_cmd("R6", 32'h2000, 4, 1, 1, 1, 0, 0, 8, 0, 1);
    run_cmd("R4", 32'h2000, 4, 0, 1, 1, 1, 1, 1, 1, 0);
    run_cmd("R4", 32'h3000, 3, 0, 0, 1, 0, 0, 20, 0, 0);
    run_cmd("R9", 32'h5000, 0, 1, 0, 1, 1, 0, 0, 0, 0);
    run_cmd("R9", 32'h5000, 1, 1, 0, 1, 1, 1, 0, 0, 0);
    run_cmd("R10", 32'h6000, 255, 1, 0, 1, 0, 0, 250, 2, 1);
    run_cmd("R12", 32'h7000, 2, 1, 0, 0, 1, 0, 5, 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule